// File: doc/BRIEF.md
# Single-Register Interrupt Aggregator

This block collects a small, parameterised group of interrupt source lines and presents them through a single 32-bit register. A register bus with byte enables reaches that register. Each source owns two bits. The first is an enable bit in the lower half of the register. The second is a sticky pending bit placed exactly 16 positions above its enable. A source line that is high sets its pending bit whether or not the source is enabled. Software clears a pending bit by writing 1 to it. A single level-sensitive output goes to the parent controller. It is high whenever at least one pending bit is set together with its enable.

The set of implemented sources is a contiguous lane. `LANE_OFS` gives the position of the first source and `N_SRC` gives the number of sources. The expected configurations are 7 sources starting at bit 0, 6 starting at bit 0, and 2 starting at bit 4. Bits outside the lane do not exist: they read 0 and ignore writes. Source inputs are taken as already synchronous to `clk_i`. Reset is asynchronous and active low.

Top module: `irq_agg_top`

## Requirements
- R1: While `rst_ni` is low, all enable bits, all pending bits and `irq_o` are 0.
- R2: A write (`req_i`=1, `we_i`=1) loads enable bit `OFS+i` (bit position in the register) from `wdata_i[OFS+i]` when the byte enable covering that bit is set. `be_i[k]` covers register bits 8k+7..8k. Without a write, the enables do not change.
- R3: A source input that is high at a clock edge makes its pending bit (register bit `16+OFS+i`) read 1 after that edge, whether or not the source is enabled.
- R4: Writing 1 to a pending bit under its byte enable clears it. Writing 0 leaves it unchanged.
- R5: When a source is high in the same cycle as a write-1 clear of its pending bit, the bit stays 1.
- R6: `irq_o` is registered. After each edge it equals the OR, over all sources, of pending AND enable as they stood before that edge.
- R7: `irq_o` stays high as long as any enabled pending bit remains set.
- R8: Register bits outside the lane (enable bits other than OFS..OFS+N_SRC-1, and pending bits other than 16+OFS..16+OFS+N_SRC-1) read 0 and ignore writes.
- R9: Setting the enable of a source whose pending bit is already set raises `irq_o` one edge after the enable takes effect.
- R10: `rdata_o` always shows the live register contents. A read (`req_i`=1, `we_i`=0) changes no state.
- R11: A write-1 to a pending bit whose byte enable is clear has no effect on that pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables, bit k covers data bits 8k+7..8k |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Live register value |
| src_i | input | N_SRC | Interrupt source lines, synchronous to clk_i |
| irq_o | output | 1 | Combined level interrupt to the parent |

## Verification
A pending bit that is lost or set by mistake shows on `rdata_o` right after the edge that should have set it. It shows on `irq_o` one edge later if the source is enabled. An enable bit that flips without cause changes the read value at once. It can also hold `irq_o` high when it should be low, or low when it should be high, from the next edge on. This matters most for the clear-versus-set collision and for byte-enable gating. In both cases a wrong result stays set, so it remains visible on every later read until a clear is issued.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = 16;
  localparam int BE_W   = REG_W / 8;

  function automatic logic [REG_W-1:0] lane_mask(input int n, input int ofs);
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < HALF_W; b++) begin
      if (b >= ofs && b < ofs + n) begin
        m[b]          = 1'b1;
        m[b + HALF_W] = 1'b1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_agg_wdec.sv
module irq_agg_wdec
  import irq_agg_pkg::*;
#(
  parameter int N_SRC    = 7,
  parameter int LANE_OFS = 0
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [BE_W-1:0]  be_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [N_SRC-1:0] en_we_o,
  output logic [N_SRC-1:0] en_wd_o,
  output logic [N_SRC-1:0] clr_o
);
  logic wr;
  assign wr = req_i & we_i;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lane
    localparam int EB = LANE_OFS + i;
    localparam int PB = HALF_W + LANE_OFS + i;
    assign en_we_o[i] = wr & be_i[EB/8];
    assign en_wd_o[i] = wdata_i[EB];
    assign clr_o[i]   = wr & be_i[PB/8] & wdata_i[PB];
  end
endmodule

// File: rtl/irq_agg_en_reg.sv
module irq_agg_en_reg #(
  parameter int N_SRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] we_i,
  input  logic [N_SRC-1:0] wd_i,
  output logic [N_SRC-1:0] en_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    en_o[i] <= 1'b0;
      else if (we_i[i]) en_o[i] <= wd_i[i];
    end
  end
endmodule

// File: rtl/irq_agg_pend_reg.sv
module irq_agg_pend_reg #(
  parameter int N_SRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    // set dominates clear so no event is dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[i] <= 1'b0;
      else if (src_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
  parameter int N_SRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  output logic             irq_o
);
  logic any_act;
  assign any_act = |(pend_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= any_act;
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int N_SRC    = 7,
  parameter int LANE_OFS = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [N_SRC-1:0] src_i,
  output logic             irq_o
);
  localparam int PEND_LO = HALF_W + LANE_OFS;

  logic [N_SRC-1:0] en_we, en_wd, clr, en_q, pend_q;

  irq_agg_wdec #(.N_SRC(N_SRC), .LANE_OFS(LANE_OFS)) u_wdec (
    .req_i   (req_i),
    .we_i    (we_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .en_we_o (en_we),
    .en_wd_o (en_wd),
    .clr_o   (clr)
  );

  irq_agg_en_reg #(.N_SRC(N_SRC)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (en_we),
    .wd_i   (en_wd),
    .en_o   (en_q)
  );

  irq_agg_pend_reg #(.N_SRC(N_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  irq_agg_out #(.N_SRC(N_SRC)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    rdata_o[LANE_OFS +: N_SRC] = en_q;
    rdata_o[PEND_LO  +: N_SRC] = pend_q;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int N_SRC    = 7,
  parameter int LANE_OFS = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [3:0]       be_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic [N_SRC-1:0] src_i,
  input logic             irq_o
);
  localparam logic [REG_W-1:0] MASK = lane_mask(N_SRC, LANE_OFS);
  localparam int PEND_LO = HALF_W + LANE_OFS;

  logic [N_SRC-1:0] en_v, pend_v;
  assign en_v   = rdata_o[LANE_OFS +: N_SRC];
  assign pend_v = rdata_o[PEND_LO  +: N_SRC];

  assert_irq_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(pend_v & en_v)));

  assert_unimpl_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~MASK) == '0);

  assert_en_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(en_v));

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int PB = PEND_LO + i;
    assert_pend_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_i[i] |=> pend_v[i]);
    assert_pend_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_v[i] && !(req_i && we_i && be_i[PB/8] && wdata_i[PB])) |=> pend_v[i]);
    assert_pend_nospur_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pend_v[i] && !src_i[i]) |=> !pend_v[i]);
  end
endmodule

bind irq_agg_top irq_agg_chk #(.N_SRC(N_SRC), .LANE_OFS(LANE_OFS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .be_i    (be_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .src_i   (src_i),
  .irq_o   (irq_o)
);

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  localparam int N_SRC = 2;
  localparam int OFS   = 4;
  localparam int NV    = 17;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  src = '0;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg_top #(.N_SRC(N_SRC), .LANE_OFS(OFS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  // {req_id, src, req, we, be, wdata, exp_rdata, exp_irq}
  typedef logic [80:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {8'd3,  2'b01, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0010_0000, 1'b0}, // R3 masked set
    {8'd3,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0010_0000, 1'b0}, // R3 held, masked
    {8'd2,  2'b00, 1'b1, 1'b1, 4'h1, 32'h0000_00FF, 32'h0010_0030, 1'b0}, // R2 enable write
    {8'd9,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0010_0030, 1'b1}, // R9 late enable
    {8'd7,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0010_0030, 1'b1}, // R7 level
    {8'd4,  2'b00, 1'b1, 1'b1, 4'hC, 32'h0000_0000, 32'h0010_0030, 1'b1}, // R4 write 0 keeps
    {8'd11, 2'b00, 1'b1, 1'b1, 4'h3, 32'h0030_0030, 32'h0010_0030, 1'b1}, // R11 be gated
    {8'd4,  2'b00, 1'b1, 1'b1, 4'h4, 32'h0010_0000, 32'h0000_0030, 1'b1}, // R4 clear
    {8'd6,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0000_0030, 1'b0}, // R6 drop
    {8'd5,  2'b10, 1'b1, 1'b1, 4'h4, 32'h0020_0000, 32'h0020_0030, 1'b0}, // R5 set wins
    {8'd6,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0020_0030, 1'b1}, // R6 rise
    {8'd2,  2'b00, 1'b1, 1'b1, 4'h3, 32'hFFFF_0010, 32'h0020_0010, 1'b1}, // R2 disable one
    {8'd6,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0020_0010, 1'b0}, // R6 masked
    {8'd8,  2'b00, 1'b1, 1'b1, 4'hF, 32'hFFFF_FFFF, 32'h0000_0030, 1'b0}, // R8 outside lane
    {8'd10, 2'b00, 1'b1, 1'b0, 4'hF, 32'hFFFF_FFFF, 32'h0000_0030, 1'b0}, // R10 read only
    {8'd3,  2'b11, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0030_0030, 1'b0}, // R3 both
    {8'd7,  2'b00, 1'b0, 1'b0, 4'h0, 32'h0000_0000, 32'h0030_0030, 1'b1}  // R7 both set
  };

  task automatic check(input int rid, input logic [31:0] er, input logic ei);
    n_chk++;
    if (rdata !== er || irq !== ei) begin
      n_bad++;
      $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b", rid, rdata, irq, er, ei);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 32'h0, 1'b0); // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk);
    check(1, 32'h0, 1'b0); // R1 after release
    for (int k = 0; k < NV; k++) begin
      {src, req, we, be, wdata} = VEC[k][72:33];
      @(negedge clk);
      check(int'(VEC[k][80:73]), VEC[k][32:1], VEC[k][0]);
    end
    // R1: async reset mid-run clears live state
    {src, req, we, be, wdata} = '0;
    #1 rst_ni = 1'b0;
    #1 check(1, 32'h0, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
    // R8: write outside lane only, nothing appears
    {req, we, be, wdata} = {1'b1, 1'b1, 4'hF, 32'hFFCF_FFCF};
    @(negedge clk);
    {req, we, be, wdata} = '0;
    check(8, 32'h0, 1'b0);
    // R5 + R4 on source 0 with enable: set wins, then clear
    src = 2'b01; {req, we, be, wdata} = {1'b1, 1'b1, 4'hF, 32'h0010_0010};
    @(negedge clk);
    src = '0; {req, we, be, wdata} = '0;
    check(5, 32'h0010_0010, 1'b0);
    {req, we, be, wdata} = {1'b1, 1'b1, 4'h4, 32'h0010_0000};
    @(negedge clk);
    {req, we, be, wdata} = '0;
    check(4, 32'h0000_0010, 1'b1);
    @(negedge clk);
    check(6, 32'h0000_0010, 1'b0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule